// File: doc/BRIEF.md
# VBI line blanking controller

This block makes one decision per video line: either the encoder drives blanking level, or it passes the incoming YCbCr samples through. It covers the vertical blanking interval of both the 525-line/60 Hz and the 625-line/50 Hz systems. An external line counter supplies a frame line number from 1 to the line count of the selected standard. A flag marks the second half of the active line. The block does not generate sync, equalization, burst or analog levels.

In partial-blanking mode the block opens a subset of the VBI lines for each standard. Embedded data such as wide-screen signalling, copy-generation flags or programme-delivery data can then reach the output. Lines that carry line sync or equalization pulses stay blanked in every mode. When external blanking is enabled, an active-low blank pin replaces the internal vertical blanking decision. The pin passes through a two-stage synchronizer first.

Top module: `vbi_blank_ctrl`

## Requirements
- R1: While rst_ni is low, blank_o is 1 and vbi_pass_o is 0.
- R2: With std_i=0 (525/60), external blanking disabled and partial mode off, blank_o is 1 for lines 525, 1..21 and 262..284, and 0 for lines 22..261 and 285..524. The output appears one clock after line_i is sampled.
- R3: With std_i=1 (625/50), external blanking disabled and partial mode off, blank_o is 1 for lines 624, 625, 1..22 and 311..335, and 0 for every other legal line.
- R4: With std_i=0 and partial_i=1, lines 10..21 and 274..284 give blank_o=0 and vbi_pass_o=1. Line 273 does so only when second_half_i=1.
- R5: With std_i=1 and partial_i=1, lines 7..22 and 319..335 give blank_o=0 and vbi_pass_o=1.
- R6: Lines that carry sync or equalization pulses stay blanked with vbi_pass_o=0 even in partial mode. For 525 these are lines 525, 1..9, 262..272 and the first half of 273. For 625 they are lines 624, 625, 1..6 and 311..318.
- R7: With partial_i=0, vbi_pass_o is never 1, and vbi_pass_o=1 always implies blank_o=0.
- R8: Line numbers of 0, or above 525 for std_i=0 or above 625 for std_i=1, give blank_o=1 and vbi_pass_o=0 in every mode.
- R9: With ext_blank_dis_i=0, blank_o on legal lines equals the inverse of blank_ni. A pin change appears at blank_o on the third rising clock edge after it (two synchronizer stages and the output register). An opened line passes only while blank_ni is high.
- R10: With ext_blank_dis_i=1, blank_ni has no effect on blank_o or vbi_pass_o.
- R11: std_i encodes the standard: 0 selects 525/60 and 1 selects 625/50.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 10 | Frame line number, from 1 |
| std_i | input | 1 | Standard select: 0 = 525/60, 1 = 625/50 |
| second_half_i | input | 1 | High during the second half of the active line |
| partial_i | input | 1 | Partial-blanking mode: opens the data lines |
| ext_blank_dis_i | input | 1 | 1 = ignore blank pin, 0 = use blank pin |
| blank_ni | input | 1 | External blank pin, active low, asynchronous |
| blank_o | output | 1 | Registered blank request |
| vbi_pass_o | output | 1 | Registered flag: a VBI line is passing data |

## Verification
A wrong window bound or a wrong wrap comparison shows up as one misclassified line. blank_o or vbi_pass_o takes the wrong value exactly one clock after that line number is presented. This is why every line value from 0 to past the largest count is swept for each standard, mode and half-line setting. A wrong synchronizer depth or a polarity slip moves the pin response off the third edge or inverts it, and this is caught within four clocks of a pin edge.

// File: rtl/vbi_pkg.sv
package vbi_pkg;
  typedef enum logic {
    STD_525 = 1'b0,
    STD_625 = 1'b1
  } vbi_std_e;

  localparam int unsigned LINE_W    = 10;
  localparam int unsigned LINES_525 = 525;
  localparam int unsigned LINES_625 = 625;
endpackage

// File: rtl/vbi_win_decode.sv
// Per-standard line classifier: legal range, VBI membership, opened data lines.
module vbi_win_decode #(
  parameter int unsigned LINE_W    = 10,
  parameter int unsigned TOTAL     = 525,
  parameter int unsigned VA_LO     = 525,  // wrapping window start (to TOTAL)
  parameter int unsigned VA_HI     = 21,   // wrapping window end (from 1)
  parameter int unsigned VB_LO     = 262,
  parameter int unsigned VB_HI     = 284,
  parameter int unsigned OA_LO     = 10,
  parameter int unsigned OA_HI     = 21,
  parameter int unsigned OB_LO     = 273,
  parameter int unsigned OB_HI     = 284,
  parameter int unsigned HALF_LINE = 273   // 0: no half-line case
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic              second_half_i,
  input  logic              partial_i,
  output logic              legal_o,
  output logic              vbi_o,
  output logic              open_o
);
  localparam logic [LINE_W-1:0] L_ONE   = LINE_W'(1);
  localparam logic [LINE_W-1:0] L_TOTAL = LINE_W'(TOTAL);
  localparam logic [LINE_W-1:0] L_VA_LO = LINE_W'(VA_LO);
  localparam logic [LINE_W-1:0] L_VA_HI = LINE_W'(VA_HI);
  localparam logic [LINE_W-1:0] L_VB_LO = LINE_W'(VB_LO);
  localparam logic [LINE_W-1:0] L_VB_HI = LINE_W'(VB_HI);
  localparam logic [LINE_W-1:0] L_OA_LO = LINE_W'(OA_LO);
  localparam logic [LINE_W-1:0] L_OA_HI = LINE_W'(OA_HI);
  localparam logic [LINE_W-1:0] L_OB_LO = LINE_W'(OB_LO);
  localparam logic [LINE_W-1:0] L_OB_HI = LINE_W'(OB_HI);
  localparam logic [LINE_W-1:0] L_HALF  = LINE_W'(HALF_LINE);

  function automatic logic in_rng(input logic [LINE_W-1:0] v,
                                  input logic [LINE_W-1:0] lo,
                                  input logic [LINE_W-1:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  logic win_a, win_b, open_a, open_b, half_hold;

  always_comb begin
    legal_o   = in_rng(line_i, L_ONE, L_TOTAL);
    // frame-end window wraps: two comparisons ORed
    win_a     = in_rng(line_i, L_VA_LO, L_TOTAL) || in_rng(line_i, L_ONE, L_VA_HI);
    win_b     = in_rng(line_i, L_VB_LO, L_VB_HI);
    vbi_o     = legal_o && (win_a || win_b);
    half_hold = (HALF_LINE != 0) && (line_i == L_HALF) && !second_half_i;
    open_a    = in_rng(line_i, L_OA_LO, L_OA_HI);
    open_b    = in_rng(line_i, L_OB_LO, L_OB_HI) && !half_hold;
    open_o    = partial_i && vbi_o && (open_a || open_b);
  end
endmodule

// File: rtl/vbi_pin_sync.sv
// Multi-stage synchronizer for the asynchronous blank pin.
module vbi_pin_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= {STAGES{RESET_VAL}};
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

  // R9: each stage takes the previous stage's value one clock later
  p_sync_shift_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_q[1] == $past(stage_q[0]));
endmodule

// File: rtl/vbi_blank_ctrl.sv
module vbi_blank_ctrl #(
  parameter int unsigned LINE_W      = vbi_pkg::LINE_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] line_i,
  input  logic              std_i,
  input  logic              second_half_i,
  input  logic              partial_i,
  input  logic              ext_blank_dis_i,
  input  logic              blank_ni,
  output logic              blank_o,
  output logic              vbi_pass_o
);
  import vbi_pkg::*;

  localparam int unsigned N_STD = 2;

  logic [N_STD-1:0] legal_s, vbi_s, open_s;
  logic legal, vbi, open_line, pin_q, blank_d, pass_d, blank_q, pass_q;

  for (genvar g = 0; g < N_STD; g++) begin : g_std
    if (g == 0) begin : g_525
      vbi_win_decode #(
        .LINE_W(LINE_W), .TOTAL(LINES_525),
        .VA_LO(525), .VA_HI(21), .VB_LO(262), .VB_HI(284),
        .OA_LO(10), .OA_HI(21), .OB_LO(273), .OB_HI(284), .HALF_LINE(273)
      ) u_dec (
        .line_i(line_i), .second_half_i(second_half_i), .partial_i(partial_i),
        .legal_o(legal_s[g]), .vbi_o(vbi_s[g]), .open_o(open_s[g])
      );
    end else begin : g_625
      vbi_win_decode #(
        .LINE_W(LINE_W), .TOTAL(LINES_625),
        .VA_LO(624), .VA_HI(22), .VB_LO(311), .VB_HI(335),
        .OA_LO(7), .OA_HI(22), .OB_LO(319), .OB_HI(335), .HALF_LINE(0)
      ) u_dec (
        .line_i(line_i), .second_half_i(second_half_i), .partial_i(partial_i),
        .legal_o(legal_s[g]), .vbi_o(vbi_s[g]), .open_o(open_s[g])
      );
    end
  end

  vbi_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_pin_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(blank_ni), .q_o(pin_q)
  );

  always_comb begin
    legal     = (std_i == STD_625) ? legal_s[1] : legal_s[0];
    vbi       = (std_i == STD_625) ? vbi_s[1]   : vbi_s[0];
    open_line = (std_i == STD_625) ? open_s[1]  : open_s[0];
    if (!legal)                blank_d = 1'b1;
    else if (!ext_blank_dis_i) blank_d = !pin_q;
    else                       blank_d = vbi && !open_line;
    pass_d = open_line && !blank_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blank_q <= 1'b1;
      pass_q  <= 1'b0;
    end else begin
      blank_q <= blank_d;
      pass_q  <= pass_d;
    end
  end

  assign blank_o    = blank_q;
  assign vbi_pass_o = pass_q;

  // R7: passing data never coincides with blanking
  p_pass_unblanked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vbi_pass_o |-> !blank_o);
  // R7: no data pass without partial mode
  p_no_pass_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !partial_i |=> !vbi_pass_o);
  // R8: illegal line numbers blank
  p_illegal_blank_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legal |=> (blank_o && !vbi_pass_o));
  // R10: with pin ignored, active lines are never blanked
  p_pin_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_blank_dis_i && legal && !vbi) |=> !blank_o);
  // R6: 525 sync/equalization lines at frame start stay closed
  p_sync_closed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (std_i == STD_525 && line_i >= LINE_W'(1) && line_i <= LINE_W'(9)) |=> !vbi_pass_o);
endmodule

// File: tb/sim_vbi_blank_ctrl.sv
module sim_vbi_blank_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] line = '0;
  logic       std_sel = 1'b0, half = 1'b0, partial = 1'b0, ext_dis = 1'b1, pin_n = 1'b1;
  logic       blank, pass;
  int         errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vbi_blank_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .std_i(std_sel),
    .second_half_i(half), .partial_i(partial), .ext_blank_dis_i(ext_dis),
    .blank_ni(pin_n), .blank_o(blank), .vbi_pass_o(pass)
  );

  function automatic bit e_legal(bit s, int l);
    return (l >= 1) && (l <= (s ? 625 : 525));
  endfunction
  function automatic bit e_vbi(bit s, int l);
    if (!e_legal(s, l)) return 0;
    if (s) return (l >= 624) || (l <= 22) || (l >= 311 && l <= 335);
    return (l == 525) || (l <= 21) || (l >= 262 && l <= 284);
  endfunction
  function automatic bit e_open(bit s, int l, bit h, bit p);
    if (!p || !e_legal(s, l)) return 0;
    if (s) return (l >= 7 && l <= 22) || (l >= 319 && l <= 335);
    return (l >= 10 && l <= 21) || (l >= 274 && l <= 284) || (l == 273 && h);
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s line=%0d std=%0b: actual=%0b expected=%0b",
               req, what, line, std_sel, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(2);
    chk("R1", "blank in reset", blank, 1'b1);
    chk("R1", "pass in reset", pass, 1'b0);
    rst_n = 1'b1;
    cyc(1);

    // Internal blanking sweep, pin toggled to show it is ignored (R10)
    ext_dis = 1'b1;
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < 2; p++)
        for (int h = 0; h < 2; h++)
          for (int l = 0; l <= 630; l++) begin
            string req;
            bit eb, ep;
            std_sel = s[0]; partial = p[0]; half = h[0];
            line = 10'(l); pin_n = l[0];
            cyc(1);
            ep = e_open(s[0], l, h[0], p[0]);
            eb = !e_legal(s[0], l) || (e_vbi(s[0], l) && !ep);
            if (!e_legal(s[0], l))         req = "R8";
            else if (ep)                   req = s ? "R5" : "R4";
            else if (p && e_vbi(s[0], l))  req = "R6";
            else                           req = s ? "R3" : "R2";
            chk(req, "blank", blank, eb);
            chk(p ? req : "R7", "pass", pass, ep);
          end

    // R11: standard encoding
    partial = 1'b0; std_sel = 1'b1; line = 10'd600; cyc(1);
    chk("R11", "625 line 600 active", blank, 1'b0);
    std_sel = 1'b0; cyc(1);
    chk("R11", "525 line 600 illegal", blank, 1'b1);

    // R10: pin held low on active line while ignored
    line = 10'd100; pin_n = 1'b0; cyc(4);
    chk("R10", "pin low ignored", blank, 1'b0);
    pin_n = 1'b1; cyc(3);

    // R9: external pin path latency and polarity
    ext_dis = 1'b0; partial = 1'b1; line = 10'd100; cyc(4);
    chk("R9", "pin high no blank", blank, 1'b0);
    pin_n = 1'b0;
    cyc(1); chk("R9", "pin low after 1 edge", blank, 1'b0);
    cyc(1); chk("R9", "pin low after 2 edges", blank, 1'b0);
    cyc(1); chk("R9", "pin low after 3 edges", blank, 1'b1);
    line = 10'd15; cyc(1);
    chk("R9", "open line blanked by pin", blank, 1'b1);
    chk("R9", "open line no pass with pin low", pass, 1'b0);
    pin_n = 1'b1;
    cyc(2); chk("R9", "pin release after 2 edges", blank, 1'b1);
    cyc(1); chk("R9", "pin release after 3 edges", blank, 1'b0);
    chk("R9", "open line passes with pin high", pass, 1'b1);

    // R9: pin high overrides internal blanking on closed VBI lines
    for (int s = 0; s < 2; s++)
      for (int l = 0; l <= 630; l++) begin
        std_sel = s[0]; half = 1'b1; line = 10'(l);
        cyc(1);
        chk(e_legal(s[0], l) ? "R9" : "R8", "ext blank", blank, !e_legal(s[0], l));
        chk("R9", "ext pass", pass, e_open(s[0], l, 1'b1, 1'b1));
      end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule